// File: doc/BRIEF.md
# Masked Vector Exponent Extractor

This block applies an exponent-extraction operation to every 32-bit single-precision lane of a packed vector. Each lane's result is the unbiased binary exponent of its input, floor(log2(|x|)), written as a single-precision number. Denormal inputs are normalised first. Zeros, infinities and NaNs each have a fixed result. The datapath is 512 bits wide. A vector-length code selects 4, 8 or 16 active lanes, and every bit above the active length is cleared.

Writes to the destination pass through a per-lane mask. Masking can be switched off. A lane whose mask bit is clear either keeps its old value or is cleared, depending on the zeroing control. When the source is marked as coming from memory and the broadcast flag is set, lane 0 of the source feeds every lane. A 4-bit reserved field must be all ones. Any other value flags an illegal encoding and leaves the destination as it was. The result is registered, so it appears one cycle after the input is presented. It comes with invalid and denormal flags, each OR-reduced over the lanes that were actually written.

Top module: `gx_masked_vec`

## Requirements
- R1: After a synchronous reset, `out_valid_o`, `dst_o`, `inv_o`, `den_o` and `illegal_o` are all zero.
- R2: A request taken with `in_valid_i` high produces its result, with `out_valid_o` high, on the next clock edge, and results keep request order.
- R3: For a normal input with biased exponent e, the lane result is the single-precision value of e-127. A zero of either sign gives 32'hFF800000 (negative infinity). An infinity of either sign gives 32'h7F800000.
- R4: A denormal input whose highest set fraction bit is bit k (0 to 22) gives the single-precision value of k-149 and sets the denormal flag.
- R5: A NaN input is returned with fraction bit 22 forced to one and its sign kept. The invalid flag is set only when bit 22 of the input was zero.
- R6: Lane i occupies bits [32*i+31:32*i]. `vlen_i` codes 0, 1, 2 and 3 select 4, 8, 16 and 16 active lanes, and all output bits above the active lanes are zero.
- R7: An active lane is written with its result when its mask bit is one or when `nomask_i` is one.
- R8: An active lane that is not written keeps its bits from `old_i` when `zero_i` is 0, and becomes zero when `zero_i` is 1.
- R9: With `bcast_i` and `mem_src_i` both one, every active lane operates on source lane 0. With `bcast_i` one and `mem_src_i` zero, each lane uses its own source.
- R10: When `rsv_i` differs from 4'b1111, `illegal_o` is one, `dst_o` equals `old_i` unchanged, and both flags are zero.
- R11: `inv_o` and `den_o` are the OR of the lane flags over active, written lanes only. Masked-off and inactive lanes contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request strobe |
| src_i | input | 512 | Source vector |
| old_i | input | 512 | Previous destination vector |
| mask_i | input | 16 | Per-lane write mask |
| nomask_i | input | 1 | Ignore the mask and write every active lane |
| zero_i | input | 1 | Clear unwritten lanes instead of merging |
| bcast_i | input | 1 | Broadcast lane 0 of the source |
| mem_src_i | input | 1 | Source is a memory operand |
| vlen_i | input | 2 | Vector-length code |
| rsv_i | input | 4 | Reserved field, must be all ones |
| out_valid_o | output | 1 | Result valid |
| dst_o | output | 512 | New destination vector |
| inv_o | output | 1 | Invalid flag (signalling NaN written) |
| den_o | output | 1 | Denormal flag (denormal written) |
| illegal_o | output | 1 | Reserved field was not all ones |

## Verification
The bench builds the block with its default parameters: 32-bit lanes and 16 lanes. With that width, all three vector lengths and the cleared upper region are exercised on one instance, and lane 15 sits at the very top of the 512-bit bus. The stimulus mixes directed special values (zeros, infinities, quiet and signalling NaNs, denormals at both ends of the fraction) with randomly classed lanes. Every result is compared against a bench model that builds its expected float encodings from integer arithmetic.

// File: rtl/gx_pkg.sv
package gx_pkg;
    localparam int LANE_W    = 32;
    localparam int MAX_LANES = 16;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_WIDE = 2'd3
    } vlen_e;

    typedef struct packed {
        logic [31:0] val;
        logic        inv;
        logic        den;
    } lane_res_t;

    function automatic int lanes_of(vlen_e v, int cap);
        int n;
        case (v)
            VL_128:  n = 4;
            VL_256:  n = 8;
            default: n = 16;
        endcase
        return (n > cap) ? cap : n;
    endfunction

    // small signed integer to exact single-precision encoding
    function automatic logic [31:0] int_to_f32(logic signed [8:0] n);
        logic [7:0]  mag;
        logic [4:0]  p;
        logic [30:0] sh;
        mag = n[8] ? 8'(-n) : 8'(n);
        p   = 5'd0;
        for (int b = 0; b < 8; b++)
            if (mag[b]) p = 5'(b);
        sh = 31'(mag) << (5'd23 - p);
        if (mag == 8'd0) return 32'h0000_0000;
        return {n[8], 8'd127 + 8'(p), sh[22:0]};
    endfunction
endpackage

// File: rtl/gx_lane_op.sv
module gx_lane_op
    import gx_pkg::*;
(
    input  logic [31:0] x_i,
    output lane_res_t   res_o
);
    logic [7:0]         ex;
    logic [22:0]        fr;
    logic [4:0]         msb;
    logic signed [8:0]  unb;

    assign ex = x_i[30:23];
    assign fr = x_i[22:0];

    always_comb begin
        msb = 5'd0;
        for (int b = 0; b < 23; b++)
            if (fr[b]) msb = 5'(b);
    end

    always_comb begin
        res_o = '0;
        unb   = $signed({1'b0, ex}) - 9'sd127;
        if (ex == 8'hFF) begin
            if (fr != 23'd0) begin
                res_o.val = x_i | 32'h0040_0000;
                res_o.inv = ~fr[22];
            end else begin
                res_o.val = 32'h7F80_0000;
            end
        end else if (ex == 8'h00) begin
            if (fr == 23'd0) begin
                res_o.val = 32'hFF80_0000;
            end else begin
                unb       = $signed({4'd0, msb}) - 9'sd149;
                res_o.val = int_to_f32(unb);
                res_o.den = 1'b1;
            end
        end else begin
            res_o.val = int_to_f32(unb);
        end
    end
endmodule

// File: rtl/gx_lane_write.sv
module gx_lane_write
    import gx_pkg::*;
(
    input  lane_res_t   res_i,
    input  logic [31:0] old_i,
    input  logic        active_i,
    input  logic        wr_i,
    input  logic        zero_i,
    output logic [31:0] val_o,
    output logic        inv_o,
    output logic        den_o
);
    logic take;
    assign take = active_i & wr_i;

    always_comb begin
        if (!active_i)   val_o = 32'd0;
        else if (wr_i)   val_o = res_i.val;
        else if (zero_i) val_o = 32'd0;
        else             val_o = old_i;
    end

    assign inv_o = take & res_i.inv;
    assign den_o = take & res_i.den;
endmodule

// File: rtl/gx_masked_vec.sv
module gx_masked_vec
    import gx_pkg::*;
#(
    parameter int NUM_LANES = MAX_LANES,
    parameter int L_W       = LANE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid_i,
    input  logic [NUM_LANES*L_W-1:0]   src_i,
    input  logic [NUM_LANES*L_W-1:0]   old_i,
    input  logic [NUM_LANES-1:0]       mask_i,
    input  logic                       nomask_i,
    input  logic                       zero_i,
    input  logic                       bcast_i,
    input  logic                       mem_src_i,
    input  logic [1:0]                 vlen_i,
    input  logic [3:0]                 rsv_i,
    output logic                       out_valid_o,
    output logic [NUM_LANES*L_W-1:0]   dst_o,
    output logic                       inv_o,
    output logic                       den_o,
    output logic                       illegal_o
);
    localparam int VEC_W = NUM_LANES * L_W;

    logic [VEC_W-1:0]     dst_c;
    logic [NUM_LANES-1:0] inv_v, den_v;
    logic                 legal, use_b0;
    int                   n_act;

    assign legal  = (rsv_i == 4'hF);
    assign use_b0 = bcast_i & mem_src_i;
    assign n_act  = lanes_of(vlen_e'(vlen_i), NUM_LANES);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [L_W-1:0] opnd;
        lane_res_t      res;
        logic           act;

        assign opnd = use_b0 ? src_i[L_W-1:0] : src_i[i*L_W +: L_W];
        assign act  = (i < n_act);

        gx_lane_op u_op (
            .x_i   (opnd),
            .res_o (res)
        );

        gx_lane_write u_wr (
            .res_i    (res),
            .old_i    (old_i[i*L_W +: L_W]),
            .active_i (act),
            .wr_i     (nomask_i | mask_i[i]),
            .zero_i   (zero_i),
            .val_o    (dst_c[i*L_W +: L_W]),
            .inv_o    (inv_v[i]),
            .den_o    (den_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            dst_o       <= '0;
            inv_o       <= 1'b0;
            den_o       <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                dst_o     <= legal ? dst_c : old_i;
                inv_o     <= legal & (|inv_v);
                den_o     <= legal & (|den_v);
                illegal_o <= ~legal;
            end
        end
    end

    // R2
    latency_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);

    // R10
    illegal_keeps_old_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && rsv_i != 4'hF) |=>
            (illegal_o && !inv_o && !den_o && dst_o == $past(old_i)));

    // R6
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && rsv_i == 4'hF && vlen_i == 2'd0) |=>
            (dst_o[VEC_W-1:4*L_W] == '0));

    // R11
    no_write_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && !nomask_i && mask_i == '0) |=> (!inv_o && !den_o));
endmodule

// File: tb/gx_masked_vec_tb.sv
`timescale 1ns/1ps
module gx_masked_vec_tb;
    localparam int NL = 16;
    localparam int VW = NL * 32;

    typedef struct packed {
        logic [VW-1:0] dst;
        logic          inv;
        logic          den;
        logic          ill;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src = '0, old = '0;
    logic [NL-1:0] mask = '0;
    logic          nomask = 1'b0, zero = 1'b0, bcast = 1'b0, mem = 1'b0;
    logic [1:0]    vl = 2'd0;
    logic [3:0]    rsv = 4'hF;
    logic          out_valid, inv, den, ill;
    logic [VW-1:0] dst;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    gx_masked_vec u_dut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .src_i(src), .old_i(old),
        .mask_i(mask), .nomask_i(nomask), .zero_i(zero), .bcast_i(bcast),
        .mem_src_i(mem), .vlen_i(vl), .rsv_i(rsv), .out_valid_o(out_valid),
        .dst_o(dst), .inv_o(inv), .den_o(den), .illegal_o(ill)
    );

    function automatic logic [31:0] m_f32(int n);
        int m, p;
        if (n == 0) return 32'd0;
        m = (n < 0) ? -n : n;
        p = 0;
        while ((m >> (p + 1)) != 0) p++;
        return {(n < 0) ? 1'b1 : 1'b0, 8'(127 + p), 23'((m - (1 << p)) << (23 - p))};
    endfunction

    function automatic logic [31:0] m_getexp(logic [31:0] x, output logic fi, output logic fd);
        int e, k;
        fi = 0; fd = 0;
        e = int'(x[30:23]);
        if (e == 255) begin
            if (x[22:0] != 0) begin fi = ~x[22]; return {x[31:23], 1'b1, x[21:0]}; end
            return 32'h7F80_0000;
        end
        if (e == 0) begin
            if (x[22:0] == 0) return 32'hFF80_0000;
            k = 0;
            for (int b = 0; b < 23; b++) if (x[b]) k = b;
            fd = 1;
            return m_f32(k - 149);
        end
        return m_f32(e - 127);
    endfunction

    function automatic int nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 8);
    endfunction

    function automatic logic [31:0] rnd_lane();
        logic [31:0] r;
        r = 32'(nxt()) ^ (32'(nxt()) << 9);
        case (nxt() % 5)
            0: r[30:23] = 8'h00;
            1: r[30:0]  = 31'h7F80_0000;
            2: r[30:23] = 8'hFF;
            3: r[30:0]  = 31'd0;
            default: ;
        endcase
        return r;
    endfunction

    task automatic drive(string tag);
        exp_t e;
        int   nl;
        logic fi, fd;
        logic [31:0] in, r;
        nl = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        e = '0;
        if (rsv != 4'hF) begin
            e.dst = old; e.ill = 1;
        end else begin
            for (int i = 0; i < NL; i++) begin
                if (i < nl) begin
                    in = (bcast && mem) ? src[31:0] : src[i*32 +: 32];
                    r  = m_getexp(in, fi, fd);
                    if (nomask || mask[i]) begin
                        e.dst[i*32 +: 32] = r;
                        e.inv |= fi; e.den |= fd;
                    end else begin
                        e.dst[i*32 +: 32] = zero ? 32'd0 : old[i*32 +: 32];
                    end
                end
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fill_rand();
        for (int i = 0; i < NL; i++) src[i*32 +: 32] = rnd_lane();
    endtask

    task automatic fill_old();
        for (int i = 0; i < NL; i++) old[i*32 +: 32] = 32'hA500_0000 | 32'(i);
    endtask

    task automatic set_ctl(logic [NL-1:0] m, logic nm, logic z, logic b, logic me, logic [1:0] v);
        mask = m; nomask = nm; zero = z; bcast = b; mem = me; vl = v; rsv = 4'hF;
    endtask

    initial begin : monitor
        exp_t  e;
        string t;
        forever begin
            @(posedge clk); #1;
            if (!rst && out_valid) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2: unexpected result actual=%h expected=none", dst);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({dst, inv, den, ill} !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual dst=%h inv=%b den=%b ill=%b expected dst=%h inv=%b den=%b ill=%b",
                                 t, dst, inv, den, ill, e.dst, e.inv, e.den, e.ill);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(20 * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        n_chk++;
        if ({out_valid, dst, inv, den, ill} !== '0) begin
            n_bad++;
            $display("FAIL R1: actual ov=%b dst=%h expected all zero", out_valid, dst);
        end
        fill_old();

        // R3 normals and specials, full width
        set_ctl('0, 1, 0, 0, 0, 2'd2);
        src = '0;
        src[0*32 +: 32] = 32'h3F80_0000; src[1*32 +: 32] = 32'h4000_0000;
        src[2*32 +: 32] = 32'hBF00_0000; src[3*32 +: 32] = 32'h4040_0000;
        src[4*32 +: 32] = 32'h0000_0000; src[5*32 +: 32] = 32'h8000_0000;
        src[6*32 +: 32] = 32'h7F80_0000; src[7*32 +: 32] = 32'hFF80_0000;
        src[8*32 +: 32] = 32'h7F7F_FFFF; src[9*32 +: 32] = 32'h0080_0000;
        src[10*32 +: 32] = 32'h4B00_0000; src[15*32 +: 32] = 32'hC2C8_0000;
        drive("R3");
        // R4 denormals
        src[0*32 +: 32] = 32'h0000_0001; src[1*32 +: 32] = 32'h0040_0000;
        src[2*32 +: 32] = 32'h8000_0100; src[3*32 +: 32] = 32'h007F_FFFF;
        drive("R4");
        // R5 NaNs: quiet lanes only, then a signalling one
        src = '0;
        src[0*32 +: 32] = 32'hFFC0_0000; src[1*32 +: 32] = 32'h7FC0_1234;
        drive("R5");
        src[2*32 +: 32] = 32'h7F80_0001;
        drive("R5");
        // R6 lane counts
        fill_rand();
        set_ctl('0, 1, 0, 0, 0, 2'd0); drive("R6");
        set_ctl('0, 1, 0, 0, 0, 2'd1); drive("R6");
        set_ctl('0, 1, 0, 0, 0, 2'd3); drive("R6");
        // R7 R8 masking merge and zero
        set_ctl(16'hA5C3, 0, 0, 0, 0, 2'd2); drive("R7");
        set_ctl(16'hA5C3, 0, 1, 0, 0, 2'd2); drive("R8");
        set_ctl(16'h0000, 0, 0, 0, 0, 2'd1); drive("R8");
        set_ctl(16'h0000, 1, 1, 0, 0, 2'd2); drive("R7");
        // R9 broadcast
        src[31:0] = 32'h0000_0010;
        set_ctl(16'hFFFF, 0, 0, 1, 1, 2'd2); drive("R9");
        set_ctl(16'hFFFF, 0, 0, 1, 0, 2'd2); drive("R9");
        // R11 flags only from written lanes
        src = '0;
        src[1*32 +: 32] = 32'h7F80_0001; src[2*32 +: 32] = 32'h0000_0005;
        set_ctl(16'hFFF9, 0, 0, 0, 0, 2'd2); drive("R11");
        src[5*32 +: 32] = 32'h7F80_0002; src[6*32 +: 32] = 32'h0000_0003;
        set_ctl(16'hFFFF, 1, 0, 0, 0, 2'd0); drive("R11");
        set_ctl(16'h0060, 0, 0, 0, 0, 2'd1); drive("R11");
        // R10 illegal reserved field
        fill_rand();
        set_ctl(16'hFFFF, 1, 1, 0, 0, 2'd2); rsv = 4'b0111; drive("R10");
        rsv = 4'b1110; drive("R10");
        // random mix, back to back
        for (int n = 0; n < 40; n++) begin
            fill_rand();
            for (int i = 0; i < NL; i++) old[i*32 +: 32] = 32'(nxt());
            set_ctl(NL'(nxt()), (nxt() % 4) == 0, nxt() % 2 == 1, nxt() % 2 == 1,
                    nxt() % 2 == 1, 2'(nxt()));
            drive("R3");
        end
        rsv = 4'hF;
        repeat (4) @(negedge clk);
        // R2 every request answered
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: actual pending=%0d expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule